// File: doc/BRIEF.md
# Round Subkey Sequencer for a 128-bit Feistel Block Cipher

This block turns a secret key of 128, 192 or 256 bits into the stream of 64-bit subkeys that a Feistel cipher core uses. It splits the key into a left half and a right half, each 128 bits wide. It also takes the two derived 128-bit keys (the "A" and "B" intermediates), which a separate round-function unit computes. Each subkey is then chosen by a fixed schedule: a source register, a left-rotation amount and the half that is kept.

A single start strobe captures all inputs. From the next clock on, the block emits one subkey per cycle in the order the cipher uses them. Each subkey comes with a valid flag and a class tag that marks it as a whitening, round or layer key. A one-cycle done pulse follows the last subkey. The step counter picks each schedule entry, and a barrel rotator produces the rotated source in the same cycle.

Top module: `subkey_sequencer`

## Requirements
- R1: The left key half is `key_in[255:128]` in every mode, so a 128-bit key is placed in the upper 128 bits of `key_in`. With `key_len`=0 (128-bit), the right half is zero.
- R2: With `key_len`=1 (192-bit, in `key_in[255:64]`), the right half is `key_in[127:64]` followed by its bitwise complement.
- R3: With `key_len`=2 or 3 (256-bit), the right half is `key_in[127:0]`.
- R4: Each subkey is bits [127:64] (upper) or [63:0] (lower) of a source (left half L, right half R, A or B) rotated left by 0, 15, 30, 45, 60, 77, 94 or 111.
- R5: The 128-bit mode emits 26 subkeys in this order:
  - L0 U/L, A0 U/L, L15 U/L, A15 U/L, layer A30 U/L;
  - L45 U/L, A45 U, L60 L, A60 U/L, layer L77 U/L;
  - L94 U/L, A94 U/L, L111 U/L, A111 U/L.
  - B is never used.
- R6: The 192/256-bit modes emit 34 subkeys in this order:
  - L0, B0, R15, A15, layer R30, B30, L45, A45;
  - layer L60, R60, B60, L77, layer A77, R94, A94, L111, B111.
  - Each entry gives the upper half and then the lower half.
- R7: `sk_class` is 0 for whitening keys (the first two and the last two subkeys), 2 for layer keys and 1 for round keys.
- R8: `sk_valid` is high from the cycle after the start edge, for exactly as many consecutive cycles as the mode has subkeys, and the step advances by one each cycle.
- R9: `sk_done` is high for exactly one cycle, the cycle after the last subkey, while `sk_valid` is low.
- R10: A start during an active sequence abandons it with no done pulse and begins the new sequence from its first subkey.
- R11: Synchronous reset clears `sk_valid` and `sk_done` and leaves the block idle until the next start.
- R12: Changes to `key_in`, `key_len`, `ka_in` and `kb_in` after the start edge have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures inputs and (re)starts the sequence |
| key_len | input | 2 | 0: 128-bit, 1: 192-bit, 2/3: 256-bit |
| key_in | input | 256 | Secret key, MSB-aligned |
| ka_in | input | 128 | Derived intermediate key A |
| kb_in | input | 128 | Derived intermediate key B (used by the 192/256-bit modes) |
| sk_valid | output | 1 | Subkey on `sk_data` is valid |
| sk_data | output | 64 | Current subkey, zero when not valid |
| sk_class | output | 2 | 0 whitening, 1 round, 2 layer |
| sk_done | output | 1 | One-cycle pulse after the last subkey |

## Verification
A wrong step count or mode bit shows up in the very next valid cycle. Either a subkey value or class differs from the expected schedule entry, or the valid window ends at the wrong length and the done pulse appears early or late. A wrongly captured key half shows up at the first subkey drawn from that half: L at step 0, R at step 4 in the long modes. Because the rotation is combinational from the step counter, every fault in the table or rotator is visible in the same cycle as the faulty step.

// File: rtl/subkey_sequencer.sv
module subkey_sequencer #(
  parameter int HW = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      key_len,
  input  logic [2*HW-1:0] key_in,
  input  logic [HW-1:0]   ka_in,
  input  logic [HW-1:0]   kb_in,
  output logic            sk_valid,
  output logic [HW/2-1:0] sk_data,
  output logic [1:0]      sk_class,
  output logic            sk_done
);
  localparam int SW = HW / 2;
  localparam logic [1:0] SRC_L = 2'd0, SRC_R = 2'd1, SRC_A = 2'd2, SRC_B = 2'd3;
  localparam logic [1:0] CL_W = 2'd0, CL_R = 2'd1, CL_E = 2'd2;

  logic [HW-1:0] kl_q, kr_q, ka_q, kb_q, kr_in, src_val;
  logic [2*HW-1:0] dbl;
  logic [5:0] step;
  logic [5:0] last;
  logic [4:0] pair;
  logic       long_q, active, done_q;
  logic [1:0] src, cls;
  logic [6:0] rot;

  always_comb begin
    case (key_len)
      2'd0:    kr_in = '0;
      2'd1:    kr_in = {key_in[HW-1:SW], ~key_in[HW-1:SW]};
      default: kr_in = key_in[HW-1:0];
    endcase
  end

  assign last = long_q ? 6'd33 : 6'd25;
  assign pair = step[5:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      kl_q <= '0; kr_q <= '0; ka_q <= '0; kb_q <= '0;
      long_q <= 1'b0; active <= 1'b0; done_q <= 1'b0; step <= '0;
    end else begin
      done_q <= active && (step == last) && !start;
      if (start) begin
        kl_q   <= key_in[2*HW-1:HW];
        kr_q   <= kr_in;
        ka_q   <= ka_in;
        kb_q   <= kb_in;
        long_q <= (key_len != 2'd0);
        step   <= '0;
        active <= 1'b1;
      end else if (active) begin
        if (step == last) active <= 1'b0;
        else step <= step + 6'd1;
      end
    end
  end

  always_comb begin
    src = SRC_L; rot = 7'd0; cls = CL_R;
    if (!long_q) begin
      case (pair)
        5'd0:  begin src = SRC_L; rot = 7'd0;   cls = CL_W; end
        5'd1:  begin src = SRC_A; rot = 7'd0;   end
        5'd2:  begin src = SRC_L; rot = 7'd15;  end
        5'd3:  begin src = SRC_A; rot = 7'd15;  end
        5'd4:  begin src = SRC_A; rot = 7'd30;  cls = CL_E; end
        5'd5:  begin src = SRC_L; rot = 7'd45;  end
        5'd6:  begin
          if (step[0]) begin src = SRC_L; rot = 7'd60; end
          else         begin src = SRC_A; rot = 7'd45; end
        end
        5'd7:  begin src = SRC_A; rot = 7'd60;  end
        5'd8:  begin src = SRC_L; rot = 7'd77;  cls = CL_E; end
        5'd9:  begin src = SRC_L; rot = 7'd94;  end
        5'd10: begin src = SRC_A; rot = 7'd94;  end
        5'd11: begin src = SRC_L; rot = 7'd111; end
        default: begin src = SRC_A; rot = 7'd111; cls = CL_W; end
      endcase
    end else begin
      case (pair)
        5'd0:  begin src = SRC_L; rot = 7'd0;   cls = CL_W; end
        5'd1:  begin src = SRC_B; rot = 7'd0;   end
        5'd2:  begin src = SRC_R; rot = 7'd15;  end
        5'd3:  begin src = SRC_A; rot = 7'd15;  end
        5'd4:  begin src = SRC_R; rot = 7'd30;  cls = CL_E; end
        5'd5:  begin src = SRC_B; rot = 7'd30;  end
        5'd6:  begin src = SRC_L; rot = 7'd45;  end
        5'd7:  begin src = SRC_A; rot = 7'd45;  end
        5'd8:  begin src = SRC_L; rot = 7'd60;  cls = CL_E; end
        5'd9:  begin src = SRC_R; rot = 7'd60;  end
        5'd10: begin src = SRC_B; rot = 7'd60;  end
        5'd11: begin src = SRC_L; rot = 7'd77;  end
        5'd12: begin src = SRC_A; rot = 7'd77;  cls = CL_E; end
        5'd13: begin src = SRC_R; rot = 7'd94;  end
        5'd14: begin src = SRC_A; rot = 7'd94;  end
        5'd15: begin src = SRC_L; rot = 7'd111; end
        default: begin src = SRC_B; rot = 7'd111; cls = CL_W; end
      endcase
    end
  end

  always_comb begin
    case (src)
      SRC_L:   src_val = kl_q;
      SRC_R:   src_val = kr_q;
      SRC_A:   src_val = ka_q;
      default: src_val = kb_q;
    endcase
  end

  assign dbl      = {src_val, src_val} << rot;
  assign sk_valid = active;
  assign sk_data  = !active ? '0 : (step[0] ? dbl[2*HW-SW-1:HW] : dbl[2*HW-1:2*HW-SW]);
  assign sk_class = active ? cls : CL_R;
  assign sk_done  = done_q;

  a_r9_done_valid_low: assert property (@(posedge clk) disable iff (rst)
    sk_done |-> !sk_valid);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    sk_done |=> !sk_done);
  a_r11_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sk_valid && !sk_done));
  a_r8_step_advance: assert property (@(posedge clk) disable iff (rst)
    (sk_valid && $past(sk_valid) && !$past(start) && !$past(rst)) |-> (step == $past(step) + 6'd1));
  a_r7_whiten_edges: assert property (@(posedge clk) disable iff (rst)
    (sk_valid && sk_class == CL_W) |-> (step < 6'd2 || step + 6'd2 > last));
  a_r5_no_b_short: assert property (@(posedge clk) disable iff (rst)
    (sk_valid && !long_q) |-> (src != SRC_B));
endmodule

// File: tb/sim_subkey_sequencer.sv
`timescale 1ns/1ps
module sim_subkey_sequencer;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] key_len = 2'd0;
  logic [255:0] key_in = '0;
  logic [127:0] ka_in = '0, kb_in = '0;
  logic sk_valid, sk_done;
  logic [63:0] sk_data;
  logic [1:0] sk_class;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  subkey_sequencer u0 (.clk(clk), .rst(rst), .start(start), .key_len(key_len),
    .key_in(key_in), .ka_in(ka_in), .kb_in(kb_in), .sk_valid(sk_valid),
    .sk_data(sk_data), .sk_class(sk_class), .sk_done(sk_done));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rl(input logic [127:0] x, input int n);
    return (n == 0) ? x : ((x << n) | (x >> (128 - n)));
  endfunction

  // {source 0=L 1=R 2=A 3=B, rotation, upper?, class}
  function automatic logic [11:0] sched(input int i, input bit lng);
    logic [11:0] e;
    if (!lng) case (i)
      0: e = {2'd0, 7'd0, 1'b1, 2'd0};    1: e = {2'd0, 7'd0, 1'b0, 2'd0};
      2: e = {2'd2, 7'd0, 1'b1, 2'd1};    3: e = {2'd2, 7'd0, 1'b0, 2'd1};
      4: e = {2'd0, 7'd15, 1'b1, 2'd1};   5: e = {2'd0, 7'd15, 1'b0, 2'd1};
      6: e = {2'd2, 7'd15, 1'b1, 2'd1};   7: e = {2'd2, 7'd15, 1'b0, 2'd1};
      8: e = {2'd2, 7'd30, 1'b1, 2'd2};   9: e = {2'd2, 7'd30, 1'b0, 2'd2};
      10: e = {2'd0, 7'd45, 1'b1, 2'd1};  11: e = {2'd0, 7'd45, 1'b0, 2'd1};
      12: e = {2'd2, 7'd45, 1'b1, 2'd1};  13: e = {2'd0, 7'd60, 1'b0, 2'd1};
      14: e = {2'd2, 7'd60, 1'b1, 2'd1};  15: e = {2'd2, 7'd60, 1'b0, 2'd1};
      16: e = {2'd0, 7'd77, 1'b1, 2'd2};  17: e = {2'd0, 7'd77, 1'b0, 2'd2};
      18: e = {2'd0, 7'd94, 1'b1, 2'd1};  19: e = {2'd0, 7'd94, 1'b0, 2'd1};
      20: e = {2'd2, 7'd94, 1'b1, 2'd1};  21: e = {2'd2, 7'd94, 1'b0, 2'd1};
      22: e = {2'd0, 7'd111, 1'b1, 2'd1}; 23: e = {2'd0, 7'd111, 1'b0, 2'd1};
      24: e = {2'd2, 7'd111, 1'b1, 2'd0}; default: e = {2'd2, 7'd111, 1'b0, 2'd0};
    endcase else begin
      case (i / 2)
        0: e = {2'd0, 7'd0, 1'b0, 2'd0};    1: e = {2'd3, 7'd0, 1'b0, 2'd1};
        2: e = {2'd1, 7'd15, 1'b0, 2'd1};   3: e = {2'd2, 7'd15, 1'b0, 2'd1};
        4: e = {2'd1, 7'd30, 1'b0, 2'd2};   5: e = {2'd3, 7'd30, 1'b0, 2'd1};
        6: e = {2'd0, 7'd45, 1'b0, 2'd1};   7: e = {2'd2, 7'd45, 1'b0, 2'd1};
        8: e = {2'd0, 7'd60, 1'b0, 2'd2};   9: e = {2'd1, 7'd60, 1'b0, 2'd1};
        10: e = {2'd3, 7'd60, 1'b0, 2'd1};  11: e = {2'd0, 7'd77, 1'b0, 2'd1};
        12: e = {2'd2, 7'd77, 1'b0, 2'd2};  13: e = {2'd1, 7'd94, 1'b0, 2'd1};
        14: e = {2'd2, 7'd94, 1'b0, 2'd1};  15: e = {2'd0, 7'd111, 1'b0, 2'd1};
        default: e = {2'd3, 7'd111, 1'b0, 2'd0};
      endcase
      e[2] = (i % 2 == 0);
    end
    return e;
  endfunction

  task automatic run_seq(input logic [1:0] len, input logic [255:0] key, input logic [127:0] ka,
                         input logic [127:0] kb, input bit disturb, input string tag);
    logic [127:0] el, er, s, r;
    logic [11:0] e;
    logic [63:0] exp;
    bit lng;
    int n;
    lng = (len != 2'd0);
    n = lng ? 34 : 26;
    el = key[255:128];
    er = (len == 2'd0) ? 128'd0 : (len == 2'd1) ? {key[127:64], ~key[127:64]} : key[127:0];
    @(negedge clk);
    start = 1'b1; key_len = len; key_in = key; ka_in = ka; kb_in = kb;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      key_in = ~key; ka_in = ~ka; kb_in = ~kb; key_len = len ^ 2'd1;
    end
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      e = sched(i, lng);
      case (e[11:10])
        2'd0: s = el; 2'd1: s = er; 2'd2: s = ka; default: s = kb;
      endcase
      r = rl(s, int'(e[9:3]));
      exp = e[2] ? r[127:64] : r[63:0];
      chk(sk_valid == 1'b1, "R8 valid window", {63'd0, sk_valid}, 64'd1);
      chk(sk_data == exp, tag, sk_data, exp);
      chk(sk_class == e[1:0], "R7 class", {62'd0, sk_class}, {62'd0, e[1:0]});
      chk(sk_done == 1'b0, "R10/R9 no done mid-sequence", {63'd0, sk_done}, 64'd0);
    end
    @(negedge clk);
    chk(sk_valid == 1'b0, "R8 valid ends", {63'd0, sk_valid}, 64'd0);
    chk(sk_done == 1'b1, "R9 done pulse", {63'd0, sk_done}, 64'd1);
    @(negedge clk);
    chk(sk_done == 1'b0, "R9 done single", {63'd0, sk_done}, 64'd0);
  endtask

  task automatic t_reset_state;
    chk(sk_valid == 1'b0, "R11 reset valid", {63'd0, sk_valid}, 64'd0);
    chk(sk_done == 1'b0, "R11 reset done", {63'd0, sk_done}, 64'd0);
    chk(sk_data == 64'd0, "R11 reset data", sk_data, 64'd0);
  endtask

  task automatic t_abort;
    @(negedge clk);
    start = 1'b1; key_len = 2'd0; key_in = {128'h55aa_33cc_0f0f_f0f0_1234_5678_9abc_def0, 128'd0};
    ka_in = 128'h1; kb_in = 128'h2;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    run_seq(2'd2, {128'hdead_beef_0000_1111_2222_3333_4444_5555, 128'h6666_7777_8888_9999_aaaa_bbbb_cccc_dddd},
            128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 128'h8000_0000_0000_0001_8000_0000_0000_0001, 1'b0,
            "R10 restart subkey");
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    start = 1'b1; key_len = 2'd1; key_in = {256{1'b1}};
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(sk_valid == 1'b0, "R11 reset aborts", {63'd0, sk_valid}, 64'd0);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk(sk_valid == 1'b0, "R11 stays idle", {63'd0, sk_valid}, 64'd0);
    chk(sk_done == 1'b0, "R11 no done", {63'd0, sk_done}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    run_seq(2'd0, {128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 128'h0},
            128'hc0de_f00d_1357_9bdf_2468_ace0_1122_3344, 128'hffff_0000_ffff_0000_ffff_0000_ffff_0000, 1'b0,
            "R1 R4 R5 subkey");
    run_seq(2'd1, {192'h0011_2233_4455_6677_8899_aabb_ccdd_eeff_0123_4567_89ab_cdef, 64'h0},
            128'h9e37_79b9_7f4a_7c15_f39c_c060_5ced_c834, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 1'b0,
            "R2 R6 subkey");
    run_seq(2'd2, {128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff},
            128'h5a5a_a5a5_3c3c_c3c3_0f0f_f0f0_6969_9696, 128'h0102_0408_1020_4080_8040_2010_0804_0201, 1'b0,
            "R3 R6 subkey");
    run_seq(2'd3, {256'h8000_0000_0000_0000_0000_0000_0000_0001_7fff_ffff_ffff_ffff_ffff_ffff_ffff_fffe},
            128'h0000_0000_0000_0001_0000_0000_0000_0000, 128'hffff_ffff_ffff_fffe_0000_0000_0000_0003, 1'b0,
            "R3 mode3 subkey");
    run_seq(2'd0, {128'hfedc_ba98_7654_3210_0123_4567_89ab_cdef, 128'h0},
            128'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0, 128'h0, 1'b1, "R12 inputs ignored");
    run_seq(2'd1, {192'hface_cafe_beef_b00c_1234_0000_ffff_a5a5_0000_0000_0000_0001, 64'h0},
            128'h1, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 1'b1, "R12 inputs ignored long");
    t_abort();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule